// File: doc/BRIEF.md
# Thread Start Sequencer for an Eight-by-Eight Multicore

After reset, this block brings up the hardware threads of a processor with 8 cores of 8 threads each. It drives the write port of a running-state register. That register has write-one-to-set behaviour and lies outside the block. The block starts one thread per write, in a fixed three-phase order:

1. The lowest enabled thread of the lowest core that has any enabled thread.
2. The lowest enabled thread of each other populated core, with the cores taken in pseudo-random order.
3. Every thread still waiting, in pseudo-random order.

Between two writes the block stays idle for a pseudo-random number of cycles. That number lies within a window set by two limit inputs.

The block holds off its first write until a free-running cycle count, supplied from outside, reaches a threshold. The threshold is 12 in normal mode and 38 when the power-on-state mode input is set. It samples the enable mask at that moment. When every enabled thread has been started, it raises a completion flag. The flag stays high until reset. An internal 16-bit LFSR supplies all random choices. Each random pick is a search that starts at a random point and takes the first candidate it finds, so a pick always finds a candidate in one cycle.

Top module: `thread_unpark_seq`

## Requirements
- R1: While reset is low, `runWrValid` and `seqDone` are 0. After reset, no write occurs while `cycleCount` is below 12. With `forcePor` = 0 and at least one enabled thread, the first write appears in a cycle where `cycleCount` is 12, 13 or 14.
- R2: With `forcePor` = 1, no write occurs while `cycleCount` is below 38, and the first write appears in a cycle where `cycleCount` is 38, 39 or 40.
- R3: If `threadEnable` is all zeros, no write ever occurs. `seqDone` rises in the cycle where `cycleCount` equals the threshold (12 or 38) plus 2.
- R4: The first write starts the lowest-numbered set bit of `threadEnable`. That bit is the lowest enabled thread of the lowest populated core.
- R5: Until every populated core has had one thread started, each write goes to a core with no started thread, and it starts that core's lowest enabled thread.
- R6: Each enabled thread is started exactly once, and a disabled thread is never started.
- R7: A write is a cycle with `runWrValid` = 1. In such a cycle, `runWrData` has exactly one bit set, at index core*8 + thread, and `runWrTid` equals that index. Outside write cycles, `runWrData` is 0.
- R8: The number of idle cycles between two consecutive writes lies between `gapMin` and `gapMax` inclusive. If `gapMax` < `gapMin`, the number is exactly `gapMin`. It may be 0, which gives back-to-back writes.
- R9: `seqDone` rises in the cycle right after the last write and then stays high until reset, with no further writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| threadEnable | input | 64 | One bit per thread, index core*8+thread; sampled when the start threshold is reached |
| cycleCount | input | 16 | Free-running cycle count since reset |
| forcePor | input | 1 | Raises the start threshold from 12 to 38 |
| gapMin | input | 8 | Lower bound of idle cycles between writes |
| gapMax | input | 8 | Upper bound of idle cycles between writes |
| runWrValid | output | 1 | Write strobe to the running register |
| runWrData | output | 64 | One-hot write data |
| runWrTid | output | 6 | Index of the thread being started |
| seqDone | output | 1 | All enabled threads started; held until reset |

## Verification
The hardest case to reach is the middle phase running against many populated cores while threads in already-started cores are still waiting. Only that combination shows whether the block wrongly slips a second thread of a core ahead of a core that has not started yet. The vector table therefore includes a full mask and a diagonal mask with one thread per core. It also includes sparse multi-thread masks whose lowest core is not core 0. A zero gap window makes writes back to back, and an inverted window pins the gap to its lower bound. The ordering is checked at every write against a started-thread record kept by the bench.

// File: rtl/unpark_pkg.sv
package unpark_pkg;

  typedef enum logic [1:0] {
    PH_FIRST = 2'd0,
    PH_CORES = 2'd1,
    PH_REST  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    S_WAIT  = 2'd0,
    S_ISSUE = 2'd1,
    S_GAP   = 2'd2,
    S_DONE  = 2'd3
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   loadMask;
    logic   issue;
    logic   loadGap;
    logic   gapTick;
    logic   finish;
    phase_e phase;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic maskEmpty;
    logic nextEmpty;
    logic coresLeft;
    logic gapZero;
    logic gapLast;
  } dpStatus_t;

endpackage

// File: rtl/unpark_ctrl.sv
module unpark_ctrl
  import unpark_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int EARLY_LIMIT = 12,
  parameter int POR_LIMIT   = 38
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cycleCount,
  input  logic             forcePor,
  input  dpStatus_t        st,
  output ctlStrobe_t       ctl
);

  state_e stateQ, stateD;
  phase_e phaseQ, phaseD;
  logic   thresholdMet;

  always_comb begin
    if (forcePor) thresholdMet = (cycleCount >= CNT_W'(POR_LIMIT));
    else          thresholdMet = (cycleCount >= CNT_W'(EARLY_LIMIT));
  end

  always_comb begin
    stateD       = stateQ;
    phaseD       = phaseQ;
    ctl.loadMask = 1'b0;
    ctl.issue    = 1'b0;
    ctl.loadGap  = 1'b0;
    ctl.gapTick  = 1'b0;
    ctl.finish   = (stateQ == S_DONE);
    ctl.phase    = phaseQ;
    unique case (stateQ)
      S_WAIT: begin
        if (thresholdMet) begin
          ctl.loadMask = 1'b1;
          phaseD       = PH_FIRST;
          stateD       = st.maskEmpty ? S_DONE : S_ISSUE;
        end
      end
      S_ISSUE: begin
        ctl.issue   = 1'b1;
        ctl.loadGap = 1'b1;
        phaseD      = st.coresLeft ? PH_CORES : PH_REST;
        if (st.nextEmpty)    stateD = S_DONE;
        else if (st.gapZero) stateD = S_ISSUE;
        else                 stateD = S_GAP;
      end
      S_GAP: begin
        ctl.gapTick = 1'b1;
        if (st.gapLast) stateD = S_ISSUE;
      end
      S_DONE: stateD = S_DONE;
      default: stateD = S_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_WAIT;
      phaseQ <= PH_FIRST;
    end else begin
      stateQ <= stateD;
      phaseQ <= phaseD;
    end
  end

endmodule

// File: rtl/unpark_dp.sv
module unpark_dp
  import unpark_pkg::*;
#(
  parameter int          NUM_CORES        = 8,
  parameter int          THREADS_PER_CORE = 8,
  parameter int          GAP_W            = 8,
  parameter logic [15:0] LFSR_SEED        = 16'hACE1,
  localparam int         NT     = NUM_CORES * THREADS_PER_CORE,
  localparam int         TID_W  = (NT > 1) ? $clog2(NT) : 1,
  localparam int         CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NT-1:0]    threadEnable,
  input  logic [GAP_W-1:0] gapMin,
  input  logic [GAP_W-1:0] gapMax,
  input  ctlStrobe_t       ctl,
  output dpStatus_t        st,
  output logic             runWrValid,
  output logic [NT-1:0]    runWrData,
  output logic [TID_W-1:0] runWrTid,
  output logic             seqDone
);

  logic [NT-1:0]        pendingQ;
  logic [NUM_CORES-1:0] coreTodoQ;
  logic [15:0]          lfsrQ;
  logic [GAP_W-1:0]     gapCntQ;

  logic [NUM_CORES-1:0] coreEn;
  logic [NUM_CORES-1:0] lowCoreOh;
  logic [TID_W-1:0]     firstIdx;
  logic [CORE_W-1:0]    pickCore;
  logic [TID_W-1:0]     coreIdx;
  logic [TID_W-1:0]     restIdx;
  logic [TID_W-1:0]     selIdx;
  logic [NT-1:0]        selOh;
  logic [NUM_CORES-1:0] pickCoreOh;
  logic [GAP_W-1:0]     gapPick;
  logic [GAP_W:0]       gapSpan;
  logic [GAP_W:0]       gapRnd;

  // per-core enable summary
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_coreEn
    assign coreEn[c] = |threadEnable[c*THREADS_PER_CORE +: THREADS_PER_CORE];
  end

  // lowest populated core
  always_comb begin
    lowCoreOh = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (coreEn[c]) lowCoreOh = NUM_CORES'(1) << c;
    end
  end

  // phase 1: lowest pending bit overall
  always_comb begin
    firstIdx = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (pendingQ[i]) firstIdx = TID_W'(i);
    end
  end

  // phase 2: random core from the to-do set, then its lowest pending thread
  always_comb begin
    logic found;
    int   idx;
    found    = 1'b0;
    pickCore = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      idx = (int'(lfsrQ[15 -: CORE_W]) + i) % NUM_CORES;
      if (!found && coreTodoQ[idx]) begin
        found    = 1'b1;
        pickCore = CORE_W'(idx);
      end
    end
    coreIdx = '0;
    for (int t = THREADS_PER_CORE - 1; t >= 0; t--) begin
      if (pendingQ[int'(pickCore) * THREADS_PER_CORE + t])
        coreIdx = TID_W'(int'(pickCore) * THREADS_PER_CORE + t);
    end
    pickCoreOh = NUM_CORES'(1) << pickCore;
  end

  // phase 3: random start point, first pending thread at or after it
  always_comb begin
    logic found;
    int   idx;
    found   = 1'b0;
    restIdx = '0;
    for (int i = 0; i < NT; i++) begin
      idx = (int'(lfsrQ[14 -: TID_W]) + i) % NT;
      if (!found && pendingQ[idx]) begin
        found   = 1'b1;
        restIdx = TID_W'(idx);
      end
    end
  end

  always_comb begin
    unique case (ctl.phase)
      PH_FIRST: selIdx = firstIdx;
      PH_CORES: selIdx = coreIdx;
      default:  selIdx = restIdx;
    endcase
    selOh = NT'(1) << selIdx;
  end

  // gap draw within the window
  always_comb begin
    gapSpan = {1'b0, gapMax} - {1'b0, gapMin} + (GAP_W+1)'(1);
    gapRnd  = {1'b0, lfsrQ[GAP_W-1:0]};
    if (gapMax < gapMin) gapPick = gapMin;
    else                 gapPick = gapMin + GAP_W'(gapRnd % gapSpan);
  end

  always_comb begin
    st.maskEmpty = (threadEnable == '0);
    st.nextEmpty = ((pendingQ & ~selOh) == '0);
    if (ctl.phase == PH_CORES)
      st.coresLeft = ((coreTodoQ & ~pickCoreOh) != '0);
    else
      st.coresLeft = (coreTodoQ != '0);
    st.gapZero = (gapPick == '0);
    st.gapLast = (gapCntQ <= GAP_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ <= LFSR_SEED;
    end else begin
      lfsrQ <= {1'b0, lfsrQ[15:1]} ^ (lfsrQ[0] ? 16'hB400 : 16'h0000);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ   <= '0;
      coreTodoQ  <= '0;
      gapCntQ    <= '0;
      runWrValid <= 1'b0;
      runWrData  <= '0;
      runWrTid   <= '0;
      seqDone    <= 1'b0;
    end else begin
      if (ctl.loadMask) begin
        pendingQ  <= threadEnable;
        coreTodoQ <= coreEn & ~lowCoreOh;
      end else if (ctl.issue) begin
        pendingQ <= pendingQ & ~selOh;
        if (ctl.phase == PH_CORES) coreTodoQ <= coreTodoQ & ~pickCoreOh;
      end
      if (ctl.loadGap)      gapCntQ <= gapPick;
      else if (ctl.gapTick) gapCntQ <= gapCntQ - GAP_W'(1);
      runWrValid <= ctl.issue;
      runWrData  <= ctl.issue ? selOh : '0;
      runWrTid   <= ctl.issue ? selIdx : '0;
      seqDone    <= seqDone | ctl.finish;
    end
  end

endmodule

// File: rtl/thread_unpark_seq.sv
module thread_unpark_seq
  import unpark_pkg::*;
#(
  parameter int          NUM_CORES        = 8,
  parameter int          THREADS_PER_CORE = 8,
  parameter int          CNT_W            = 16,
  parameter int          GAP_W            = 8,
  parameter int          EARLY_LIMIT      = 12,
  parameter int          POR_LIMIT        = 38,
  parameter logic [15:0] LFSR_SEED        = 16'hACE1,
  localparam int         NT    = NUM_CORES * THREADS_PER_CORE,
  localparam int         TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NT-1:0]    threadEnable,
  input  logic [CNT_W-1:0] cycleCount,
  input  logic             forcePor,
  input  logic [GAP_W-1:0] gapMin,
  input  logic [GAP_W-1:0] gapMax,
  output logic             runWrValid,
  output logic [NT-1:0]    runWrData,
  output logic [TID_W-1:0] runWrTid,
  output logic             seqDone
);

  ctlStrobe_t ctl;
  dpStatus_t  st;

  unpark_ctrl #(
    .CNT_W(CNT_W), .EARLY_LIMIT(EARLY_LIMIT), .POR_LIMIT(POR_LIMIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cycleCount(cycleCount), .forcePor(forcePor),
    .st(st), .ctl(ctl)
  );

  unpark_dp #(
    .NUM_CORES(NUM_CORES), .THREADS_PER_CORE(THREADS_PER_CORE),
    .GAP_W(GAP_W), .LFSR_SEED(LFSR_SEED)
  ) dp_i (
    .clk(clk), .rstN(rstN), .threadEnable(threadEnable),
    .gapMin(gapMin), .gapMax(gapMax), .ctl(ctl), .st(st),
    .runWrValid(runWrValid), .runWrData(runWrData), .runWrTid(runWrTid),
    .seqDone(seqDone)
  );

endmodule

// File: rtl/unpark_checker.sv
module unpark_checker #(
  parameter int  NUM_CORES        = 8,
  parameter int  THREADS_PER_CORE = 8,
  parameter int  CNT_W            = 16,
  parameter int  GAP_W            = 8,
  parameter int  EARLY_LIMIT      = 12,
  parameter int  POR_LIMIT        = 38,
  localparam int NT    = NUM_CORES * THREADS_PER_CORE,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [NT-1:0]    threadEnable,
  input logic [CNT_W-1:0] cycleCount,
  input logic             forcePor,
  input logic [GAP_W-1:0] gapMin,
  input logic [GAP_W-1:0] gapMax,
  input logic             runWrValid,
  input logic [NT-1:0]    runWrData,
  input logic [TID_W-1:0] runWrTid,
  input logic             seqDone
);

  logic [NT-1:0]        started;
  logic                 anyWritten;
  logic [8:0]           idle;
  logic [NUM_CORES-1:0] coreEnC, coreStartedC;
  logic [NT-1:0]        lowestEnOh, coreLowOh;
  logic                 curCoreStarted;
  logic                 idleOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      started    <= '0;
      anyWritten <= 1'b0;
      idle       <= '0;
    end else begin
      if (runWrValid) begin
        started    <= started | runWrData;
        anyWritten <= 1'b1;
        idle       <= '0;
      end else if (idle != 9'h1FF) begin
        idle <= idle + 9'd1;
      end
    end
  end

  always_comb begin
    int cur;
    for (int c = 0; c < NUM_CORES; c++) begin
      coreEnC[c]      = |threadEnable[c*THREADS_PER_CORE +: THREADS_PER_CORE];
      coreStartedC[c] = |started[c*THREADS_PER_CORE +: THREADS_PER_CORE];
    end
    lowestEnOh = '0;
    for (int i = NT - 1; i >= 0; i--) if (threadEnable[i]) lowestEnOh = NT'(1) << i;
    cur            = int'(runWrTid) / THREADS_PER_CORE;
    curCoreStarted = coreStartedC[cur];
    coreLowOh      = '0;
    for (int t = THREADS_PER_CORE - 1; t >= 0; t--)
      if (threadEnable[cur*THREADS_PER_CORE + t])
        coreLowOh = NT'(1) << (cur*THREADS_PER_CORE + t);
    if (gapMax < gapMin) idleOk = (idle == {1'b0, gapMin});
    else idleOk = (idle >= {1'b0, gapMin}) && (idle <= {1'b0, gapMax});
  end

  a_r1_not_early: assert property (@(posedge clk) disable iff (!rstN)
    runWrValid && !anyWritten |-> cycleCount >= CNT_W'(EARLY_LIMIT));

  a_r2_por_hold: assert property (@(posedge clk) disable iff (!rstN)
    runWrValid && !anyWritten && forcePor |-> cycleCount >= CNT_W'(POR_LIMIT));

  a_r3_empty_no_write: assert property (@(posedge clk) disable iff (!rstN)
    threadEnable == '0 |-> !runWrValid);

  a_r4_first_lowest: assert property (@(posedge clk) disable iff (!rstN)
    runWrValid && !anyWritten |-> runWrData == lowestEnOh);

  a_r5_cores_first: assert property (@(posedge clk) disable iff (!rstN)
    runWrValid && curCoreStarted |-> (coreEnC & ~coreStartedC) == '0);

  a_r5_core_lowest: assert property (@(posedge clk) disable iff (!rstN)
    runWrValid && !curCoreStarted |-> runWrData == coreLowOh);

  a_r6_once: assert property (@(posedge clk) disable iff (!rstN)
    runWrValid |-> ((runWrData & started) == '0) && ((runWrData & ~threadEnable) == '0));

  a_r7_onehot: assert property (@(posedge clk) disable iff (!rstN)
    runWrValid |-> ($countones(runWrData) == 1) && runWrData[runWrTid]);

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !runWrValid |-> runWrData == '0);

  a_r8_gap: assert property (@(posedge clk) disable iff (!rstN)
    runWrValid && anyWritten |-> idleOk);

  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> seqDone);

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !runWrValid);

  a_r9_done_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqDone) |-> started == threadEnable);

endmodule

bind thread_unpark_seq unpark_checker #(
  .NUM_CORES(NUM_CORES), .THREADS_PER_CORE(THREADS_PER_CORE), .CNT_W(CNT_W),
  .GAP_W(GAP_W), .EARLY_LIMIT(EARLY_LIMIT), .POR_LIMIT(POR_LIMIT)
) chk_i (.*);

// File: tb/thread_unpark_seq_tb_top.sv
module thread_unpark_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 7;

  typedef struct packed {
    logic [63:0] mask;
    logic        por;
    logic [7:0]  gmin;
    logic [7:0]  gmax;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{mask: 64'h0000_0000_0000_0000, por: 1'b0, gmin: 8'd1, gmax: 8'd3},
    '{mask: 64'hFFFF_FFFF_FFFF_FFFF, por: 1'b0, gmin: 8'd0, gmax: 8'd3},
    '{mask: 64'h0100_0000_0000_0000, por: 1'b1, gmin: 8'd2, gmax: 8'd2},
    '{mask: 64'h8040_2010_0804_0201, por: 1'b0, gmin: 8'd1, gmax: 8'd4},
    '{mask: 64'hF0F0_0000_00FF_0000, por: 1'b1, gmin: 8'd5, gmax: 8'd1},
    '{mask: 64'h00FF_FF00_FF00_0000, por: 1'b0, gmin: 8'd0, gmax: 8'd0},
    '{mask: 64'h8000_0000_0000_0000, por: 1'b1, gmin: 8'd3, gmax: 8'd7}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] threadEnable = '0;
  logic [15:0] cycleCount;
  logic        forcePor = 1'b0;
  logic [7:0]  gapMin = '0, gapMax = '0;
  logic        runWrValid;
  logic [63:0] runWrData;
  logic [5:0]  runWrTid;
  logic        seqDone;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rstN) cycleCount <= '0;
    else       cycleCount <= cycleCount + 16'd1;
  end

  thread_unpark_seq dut_i (
    .clk(clk), .rstN(rstN), .threadEnable(threadEnable), .cycleCount(cycleCount),
    .forcePor(forcePor), .gapMin(gapMin), .gapMax(gapMax),
    .runWrValid(runWrValid), .runWrData(runWrData), .runWrTid(runWrTid),
    .seqDone(seqDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset(input vec_t v);
    threadEnable = v.mask;
    forcePor     = v.por;
    gapMin       = v.gmin;
    gapMax       = v.gmax;
    rstN         = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runVector(input vec_t v);
    int          thr, nWr, firstCnt, lastCyc, doneCyc, cyc, lowIdx, idleV;
    int          ordErr, gapErr, bitErr, expMax, pop;
    logic [63:0] startedM;
    logic [7:0]  coreSeen, coreEn;
    thr = v.por ? 38 : 12;
    expMax = (v.gmax < v.gmin) ? int'(v.gmin) : int'(v.gmax);
    nWr = 0; firstCnt = -1; lastCyc = -1; doneCyc = -1;
    ordErr = 0; gapErr = 0; bitErr = 0; startedM = '0; coreSeen = '0;
    lowIdx = -1; pop = 0;
    for (int i = 63; i >= 0; i--) if (v.mask[i]) lowIdx = i;
    for (int i = 0; i < 64; i++) if (v.mask[i]) pop++;
    for (int c = 0; c < 8; c++) coreEn[c] = |v.mask[c*8 +: 8];
    doReset(v);
    cyc = 0;
    while (doneCyc < 0 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (runWrValid) begin
        int tid, core;
        tid  = int'(runWrTid);
        core = tid / 8;
        if (runWrData != (64'd1 << tid) || !v.mask[tid] || startedM[tid]) bitErr++;
        if (nWr == 0) begin
          firstCnt = int'(cycleCount);
          if (tid != lowIdx) ordErr++;
        end else begin
          idleV = cyc - lastCyc - 1;
          if (idleV < int'(v.gmin) || idleV > expMax) gapErr++;
          if (coreSeen[core]) begin
            if ((coreEn & ~coreSeen) != 8'h00) ordErr++;
          end else begin
            for (int t = 0; t < 8; t++)
              if (v.mask[core*8 + t] && t < tid % 8) ordErr++;
          end
        end
        coreSeen[core] = 1'b1;
        startedM[tid]  = 1'b1;
        lastCyc = cyc;
        nWr++;
      end
      if (seqDone) doneCyc = cyc;
    end
    check(doneCyc >= 0, "R9", "done reached", doneCyc, 1);
    check(startedM == v.mask, "R6", "started set", startedM, v.mask);
    check(nWr == pop, "R6", "write count", nWr, pop);
    check(bitErr == 0, "R7", "one-hot/once errors", bitErr, 0);
    check(ordErr == 0, "R5", "order errors (R4 first pick)", ordErr, 0);
    check(gapErr == 0, "R8", "gap errors", gapErr, 0);
    if (pop == 0) begin
      check(nWr == 0, "R3", "writes on empty mask", nWr, 0);
      check(int'(cycleCount) == thr + 2, "R3", "done at count", cycleCount, thr + 2);
    end else begin
      if (v.por)
        check(firstCnt >= thr && firstCnt <= thr + 2, "R2", "first write count", firstCnt, thr + 2);
      else
        check(firstCnt >= thr && firstCnt <= thr + 2, "R1", "first write count", firstCnt, thr + 2);
      check(doneCyc == lastCyc + 1, "R9", "done after last write", doneCyc, lastCyc + 1);
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(seqDone && !runWrValid, "R9", "done held, no write", {seqDone, runWrValid}, 2'b10);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // reset state
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!runWrValid && !seqDone, "R1", "outputs in reset", {runWrValid, seqDone}, 0);

    // table walk
    for (int n = 0; n < NVEC; n++) runVector(VECS[n]);

    // directed: reset in mid-sequence clears outputs
    doReset(VECS[1]);
    repeat (30) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!runWrValid && !seqDone && runWrData == '0, "R1", "reset mid-run",
          {runWrValid, seqDone}, 0);
    @(negedge clk);

    // directed: no write before threshold in normal mode
    doReset('{mask: 64'h0000_0000_0000_0002, por: 1'b0, gmin: 8'd0, gmax: 8'd0});
    begin
      int early;
      early = 0;
      while (cycleCount < 16'd12) begin
        @(negedge clk);
        if (runWrValid && cycleCount < 16'd12) early++;
      end
      check(early == 0, "R1", "writes before count 12", early, 0);
    end

    // directed: power-on mode, nothing before 38
    doReset('{mask: 64'h0000_0001_0000_0000, por: 1'b1, gmin: 8'd0, gmax: 8'd0});
    begin
      int early;
      early = 0;
      while (cycleCount < 16'd38) begin
        @(negedge clk);
        if (runWrValid && cycleCount < 16'd38) early++;
      end
      check(early == 0, "R2", "writes before count 38", early, 0);
      repeat (3) @(negedge clk);
      check(seqDone == 1'b1, "R9", "done after single start", seqDone, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule